// File: doc/BRIEF.md
# Prioritized Error Address Capture

This block is the error-address status register of a flash controller. Four kinds of error event report to it: an uncorrectable (double-bit) ECC error, a read-while-write conflict, a failed program/erase operation and a corrected single-bit ECC event. Each event arrives as a one-cycle pulse. The pulse comes with the byte address of the access. The two ECC kinds also carry a flag saying that both double words of the page were hit in the same cycle.

Each class keeps its own status flag and the double-word address of its first event. A later event of the same class leaves that address unchanged until software clears the flag. The register read port shows the stored address of the most urgent class that is currently flagged. When no class is flagged, it keeps showing what it showed last. A privileged write can load the value that is shown while the port is idle.

Top module: `err_addr_capture`

## Requirements
- R1: Read selection follows a fixed priority, highest first: uncorrectable ECC, read-while-write, operation failure, corrected ECC. `rd_data` shows the stored address of the highest flagged class.
- R2: A class stores the address of its first event only. Further events of that class leave the stored address unchanged while its flag stays set.
- R3: The operation-failure flag `op_pass` is active low. It reads 1 after reset, goes to 0 on `opf_ev`, and returns to 1 on `op_start`.
- R4: `rd_data[22:3]` carries address bits 22..3. Bits 2..0 and 31..23 always read 0.
- R5: When `ded_both` or `sec_both` comes with its event, the stored address has bit 3 forced to 0. The read-while-write and operation classes have no such input and keep bit 3 as given.
- R6: A one-cycle pulse on `clr_ded`, `clr_rww` or `clr_sec` drops that class's flag, and the read then falls through to the next flagged class. After a clear, the next event of the class is captured as a new first event.
- R7: `rd_data` reads 0 after reset. While no class is flagged, it holds the value it last presented.
- R8: Events of different classes in the same cycle each store their own address.
- R9: With `wr_en` and `priv_mode` both high, `wr_data[22:3]` becomes the value shown while no class is flagged. With `priv_mode` low, the write is ignored.
- R10: If an event and the clear of its class (or `op_start` for the operation class) arrive in the same cycle, the event wins. The flag stays set and the new address is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ded_ev | input | 1 | Uncorrectable ECC event pulse |
| ded_addr | input | 23 | Byte address of the uncorrectable ECC access |
| ded_both | input | 1 | Both double words of the page hit by the uncorrectable ECC event |
| rww_ev | input | 1 | Read-while-write conflict pulse |
| rww_addr | input | 23 | Byte address of the conflicting access |
| opf_ev | input | 1 | Program/erase operation failure pulse |
| opf_addr | input | 23 | Byte address of the failing operation |
| op_start | input | 1 | New operation starts; re-arms the pass flag |
| sec_ev | input | 1 | Corrected single-bit ECC event pulse |
| sec_addr | input | 23 | Byte address of the corrected access |
| sec_both | input | 1 | Both double words of the page corrected at once |
| clr_ded | input | 1 | Clear the uncorrectable ECC flag |
| clr_rww | input | 1 | Clear the read-while-write flag |
| clr_sec | input | 1 | Clear the corrected ECC flag |
| priv_mode | input | 1 | Privileged/test mode; enables writes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| ded_flag | output | 1 | Uncorrectable ECC flag |
| rww_flag | output | 1 | Read-while-write flag |
| op_pass | output | 1 | Operation pass flag (0 = failure recorded) |
| sec_flag | output | 1 | Corrected ECC flag |

## Verification
Every result in this block is due one clock after its stimulus. An event, clear, `op_start` or write is sampled at a rising edge. The flags and `rd_data` are driven only from registers, so the new value shows from that edge on. The bench drives inputs on the falling edge and compares all outputs on the next falling edge. It does this against a behavioural model that it advances on the rising edge in between. Directed steps check hand-computed values one falling edge after the pulse.

// File: rtl/erraddr_pkg.sv
package erraddr_pkg;

    localparam int ADDR_W  = 23;
    localparam int ADDR_LO = 3;
    localparam int FIELD_W = ADDR_W - ADDR_LO;
    localparam int DATA_W  = 32;
    localparam int N_CLASS = 4;

    // Index order is the read priority: lower index wins.
    typedef enum int {
        CLS_DED = 0,
        CLS_RWW = 1,
        CLS_OPF = 2,
        CLS_SEC = 3
    } err_class_e;

    typedef logic [FIELD_W-1:0] dw_addr_t;

    function automatic logic [DATA_W-1:0] field_to_reg(input dw_addr_t f);
        return {{(DATA_W-ADDR_W){1'b0}}, f, {ADDR_LO{1'b0}}};
    endfunction

endpackage

// File: rtl/err_class_slot.sv
module err_class_slot #(
    parameter int AW         = 23,
    parameter int LO         = 3,
    parameter bit ACTIVE_LOW = 1'b0,
    localparam int FW        = AW - LO
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev,
    input  logic [AW-1:0] ev_addr,
    input  logic          ev_both,
    input  logic          clr,
    output logic          active,
    output logic          flag,
    output logic [FW-1:0] cap
);
    logic          hit_q;
    logic [FW-1:0] cap_q;
    logic          take;
    logic          low_bit;
    logic          unused_lo;

    assign take      = ev && (!hit_q || clr);
    assign low_bit   = ev_addr[LO] & ~ev_both;
    assign unused_lo = ^ev_addr[LO-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            cap_q <= '0;
        end else begin
            if (ev)
                hit_q <= 1'b1;
            else if (clr)
                hit_q <= 1'b0;
            if (take)
                cap_q <= {ev_addr[AW-1:LO+1], low_bit};
        end
    end

    assign active = hit_q;
    assign cap    = cap_q;

    generate
        if (ACTIVE_LOW) begin : g_low
            assign flag = ~hit_q;
        end else begin : g_high
            assign flag = hit_q;
        end
    endgenerate

    AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hit_q && !clr) |=> $stable(cap_q)); // R2
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        ev |=> active); // R10
    AST_BOTH_LOW: assert property (@(posedge clk) disable iff (rst)
        (ev && ev_both && (!hit_q || clr)) |=> (cap_q[0] == 1'b0)); // R5

endmodule

// File: rtl/err_prio_sel.sv
module err_prio_sel #(
    parameter int N  = 4,
    parameter int FW = 20
) (
    input  logic [N-1:0]         act,
    input  logic [N-1:0][FW-1:0] caps,
    output logic                 any,
    output logic [FW-1:0]        sel
);
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act[i]) begin
                any = 1'b1;
                sel = caps[i];
            end
        end
    end
endmodule

// File: rtl/err_addr_capture.sv
module err_addr_capture
    import erraddr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int LO = ADDR_LO,
    localparam int FW = AW - LO,
    localparam int NC = N_CLASS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ded_ev,
    input  logic [AW-1:0] ded_addr,
    input  logic          ded_both,
    input  logic          rww_ev,
    input  logic [AW-1:0] rww_addr,
    input  logic          opf_ev,
    input  logic [AW-1:0] opf_addr,
    input  logic          op_start,
    input  logic          sec_ev,
    input  logic [AW-1:0] sec_addr,
    input  logic          sec_both,
    input  logic          clr_ded,
    input  logic          clr_rww,
    input  logic          clr_sec,
    input  logic          priv_mode,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          ded_flag,
    output logic          rww_flag,
    output logic          op_pass,
    output logic          sec_flag
);
    logic [NC-1:0]          ev_v, both_v, clr_v, act_v, flag_v;
    logic [NC-1:0][AW-1:0]  addr_v;
    logic [NC-1:0][FW-1:0]  cap_v;
    logic                   any_act;
    logic [FW-1:0]          sel_field;
    logic [FW-1:0]          shown;
    logic [FW-1:0]          hold_q;
    logic                   wr_ok;
    logic                   unused_wr;

    assign ev_v   = {sec_ev, opf_ev, rww_ev, ded_ev};
    assign both_v = {sec_both, 1'b0, 1'b0, ded_both};
    assign clr_v  = {clr_sec, op_start, clr_rww, clr_ded};
    assign addr_v = {sec_addr, opf_addr, rww_addr, ded_addr};

    generate
        for (genvar g = 0; g < NC; g++) begin : g_slot
            err_class_slot #(
                .AW(AW), .LO(LO), .ACTIVE_LOW(g == CLS_OPF)
            ) i_slot (
                .clk    (clk),
                .rst    (rst),
                .ev     (ev_v[g]),
                .ev_addr(addr_v[g]),
                .ev_both(both_v[g]),
                .clr    (clr_v[g]),
                .active (act_v[g]),
                .flag   (flag_v[g]),
                .cap    (cap_v[g])
            );
        end
    endgenerate

    err_prio_sel #(.N(NC), .FW(FW)) i_sel (
        .act (act_v),
        .caps(cap_v),
        .any (any_act),
        .sel (sel_field)
    );

    assign shown     = any_act ? sel_field : hold_q;
    assign wr_ok     = wr_en && priv_mode;
    assign unused_wr = ^{wr_data[DW-1:AW], wr_data[LO-1:0]};

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (wr_ok)
            hold_q <= wr_data[AW-1:LO];
        else
            hold_q <= shown;
    end

    assign rd_data  = field_to_reg(shown);
    assign ded_flag = flag_v[CLS_DED];
    assign rww_flag = flag_v[CLS_RWW];
    assign op_pass  = flag_v[CLS_OPF];
    assign sec_flag = flag_v[CLS_SEC];

    AST_TOP_CLASS: assert property (@(posedge clk) disable iff (rst)
        act_v[CLS_DED] |-> (rd_data[AW-1:LO] == cap_v[CLS_DED])); // R1
    AST_SECOND_CLASS: assert property (@(posedge clk) disable iff (rst)
        (!act_v[CLS_DED] && act_v[CLS_RWW]) |-> (rd_data[AW-1:LO] == cap_v[CLS_RWW])); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!any_act && !wr_ok) |=> (any_act || $stable(rd_data))); // R7
    AST_PRIV_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> (any_act || rd_data[AW-1:LO] == $past(wr_data[AW-1:LO]))); // R9

endmodule

// File: tb/test_err_addr_capture.sv
`timescale 1ns/1ps
module test_err_addr_capture;

    logic        clk = 1'b0;
    logic        rst;
    logic        ded_ev, ded_both, rww_ev, opf_ev, op_start, sec_ev, sec_both;
    logic [22:0] ded_addr, rww_addr, opf_addr, sec_addr;
    logic        clr_ded, clr_rww, clr_sec, priv_mode, wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        ded_flag, rww_flag, op_pass, sec_flag;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model state, class order: ded, rww, opf, sec
    bit hit[4];
    int cap[4];
    int hold;

    always #10 clk = ~clk;

    err_addr_capture i_err_addr_capture (
        .clk(clk), .rst(rst),
        .ded_ev(ded_ev), .ded_addr(ded_addr), .ded_both(ded_both),
        .rww_ev(rww_ev), .rww_addr(rww_addr),
        .opf_ev(opf_ev), .opf_addr(opf_addr), .op_start(op_start),
        .sec_ev(sec_ev), .sec_addr(sec_addr), .sec_both(sec_both),
        .clr_ded(clr_ded), .clr_rww(clr_rww), .clr_sec(clr_sec),
        .priv_mode(priv_mode), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ded_flag(ded_flag), .rww_flag(rww_flag),
        .op_pass(op_pass), .sec_flag(sec_flag)
    );

    function automatic int model_read();
        for (int k = 0; k < 4; k++)
            if (hit[k]) return cap[k];
        return hold;
    endfunction

    function automatic int dw(input logic [22:0] a, input logic both);
        int v;
        v = int'(a) & 32'h007F_FFF8;
        if (both) v = v & ~32'h8;
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        ded_ev = 0; ded_both = 0; rww_ev = 0; opf_ev = 0; op_start = 0;
        sec_ev = 0; sec_both = 0; clr_ded = 0; clr_rww = 0; clr_sec = 0;
        wr_en = 0; priv_mode = 0; wr_data = '0;
        ded_addr = '0; rww_addr = '0; opf_addr = '0; sec_addr = '0;
    endtask

    // model advance on the rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) begin hit[k] = 0; cap[k] = 0; end
            hold = 0;
        end else begin
            bit          e[4];
            bit          c[4];
            int          a[4];
            e = '{ded_ev, rww_ev, opf_ev, sec_ev};
            c = '{clr_ded, clr_rww, op_start, clr_sec};
            a = '{dw(ded_addr, ded_both), dw(rww_addr, 1'b0),
                  dw(opf_addr, 1'b0), dw(sec_addr, sec_both)};
            hold = (wr_en && priv_mode) ? (int'(wr_data) & 32'h007F_FFF8) : model_read();
            for (int k = 0; k < 4; k++) begin
                if (e[k] && (!hit[k] || c[k])) cap[k] = a[k];
                if (e[k]) hit[k] = 1;
                else if (c[k]) hit[k] = 0;
            end
        end
    end

    // per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1/R7 model rd_data", int'(rd_data), model_read());
            chk("R3 model op_pass", int'(op_pass), int'(!hit[2]));
            chk("R6 model flags", int'({ded_flag, rww_flag, sec_flag}),
                int'({hit[0], hit[1], hit[3]}));
        end
    end

    initial begin
        #(20ns * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R7 reset rd_data", int'(rd_data), 0);
        chk("R3 reset op_pass", int'(op_pass), 1);

        sec_ev = 1; sec_addr = 23'h00010F;
        @(negedge clk); idle();
        chk("R4 low bits zero", int'(rd_data), 32'h108);

        sec_ev = 1; sec_addr = 23'h000200;
        @(negedge clk); idle();
        chk("R2 first address kept", int'(rd_data), 32'h108);

        opf_ev = 1; opf_addr = 23'h0003F4;
        @(negedge clk); idle();
        chk("R3 op_pass low", int'(op_pass), 0);
        chk("R1 op over sec", int'(rd_data), 32'h3F0);

        rww_ev = 1; rww_addr = 23'h001000;
        ded_ev = 1; ded_addr = 23'h002008; ded_both = 1;
        @(negedge clk); idle();
        chk("R5 R8 ded both halves", int'(rd_data), 32'h2000);

        clr_ded = 1;
        @(negedge clk); idle();
        chk("R6 R8 fall to rww", int'(rd_data), 32'h1000);

        clr_rww = 1;
        @(negedge clk); idle();
        chk("R6 fall to op", int'(rd_data), 32'h3F0);

        op_start = 1;
        @(negedge clk); idle();
        chk("R3 op_pass rearmed", int'(op_pass), 1);
        chk("R1 fall to sec", int'(rd_data), 32'h108);

        clr_sec = 1;
        @(negedge clk); idle();
        chk("R7 idle hold", int'(rd_data), 32'h108);

        wr_en = 1; wr_data = 32'h0777_7778;
        @(negedge clk); idle();
        chk("R9 user write ignored", int'(rd_data), 32'h108);

        wr_en = 1; priv_mode = 1; wr_data = 32'hF777_777F;
        @(negedge clk); idle();
        chk("R9 R4 privileged write", int'(rd_data), 32'h0077_7778);

        sec_ev = 1; sec_addr = 23'h000500;
        @(negedge clk); idle();
        sec_ev = 1; sec_addr = 23'h000600; clr_sec = 1;
        @(negedge clk); idle();
        chk("R10 event beats clear", int'(rd_data), 32'h600);
        chk("R10 flag stays", int'(sec_flag), 1);

        clr_sec = 1;
        @(negedge clk); idle();
        sec_ev = 1; sec_addr = 23'h000808; sec_both = 1;
        @(negedge clk); idle();
        chk("R5 R6 sec both recapture", int'(rd_data), 32'h800);

        clr_sec = 1;
        @(negedge clk); idle();
        rww_ev = 1; rww_addr = 23'h001008;
        @(negedge clk); idle();
        chk("R5 rww keeps bit3", int'(rd_data), 32'h1008);
        clr_rww = 1;
        @(negedge clk); idle();

        for (int n = 0; n < 4000; n++) begin
            ded_ev    = ($urandom_range(0, 15) == 0);
            rww_ev    = ($urandom_range(0, 11) == 0);
            opf_ev    = ($urandom_range(0, 11) == 0);
            sec_ev    = ($urandom_range(0, 5) == 0);
            ded_both  = $urandom_range(0, 1) == 1;
            sec_both  = $urandom_range(0, 1) == 1;
            ded_addr  = 23'($urandom);
            rww_addr  = 23'($urandom);
            opf_addr  = 23'($urandom);
            sec_addr  = 23'($urandom);
            clr_ded   = ($urandom_range(0, 7) == 0);
            clr_rww   = ($urandom_range(0, 7) == 0);
            clr_sec   = ($urandom_range(0, 7) == 0);
            op_start  = ($urandom_range(0, 7) == 0);
            wr_en     = ($urandom_range(0, 9) == 0);
            priv_mode = $urandom_range(0, 1) == 1;
            wr_data   = $urandom;
            @(negedge clk);
        end
        idle();
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule